// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block generates a periodic interrupt from a free-running down counter. An 8-bit prescale counter divides the clock. The division ratio is set by a scale register that holds the desired ratio minus one. Each time the prescaler expires, the 16-bit count moves one step.

When a step takes the count from one to zero, the block emits a one-cycle interrupt pulse. On the step after that, the count is refilled from a separately programmed period register. This yields an interrupt every (period + 1) × (scale + 1) cycles once the timer is running.

Software programs the count, period and scale through a single write port with a 2-bit register select. It reads the live count on a dedicated output. An enable input freezes the timer without losing its state.

Top module: `interval_timer`

## Requirements
- R1: After reset, count_o is 0 and irq_o is 0. The stored period, the scale and the prescale counter are also 0.
- R2: A write with wr_en_i high selects its register by wr_addr_i: 0 is the count, 1 is the period, 2 is the scale (wr_data_i[7:0] used). A write with wr_addr_i of 3 changes no state.
- R3: While en_i is high and scale holds S, the count steps once every S+1 cycles. S of 0 steps every cycle, and S of 255 steps every 256 cycles. A new scale value is picked up when the prescale counter next expires.
- R4: irq_o is high for exactly one cycle. That cycle is the first cycle in which count_o shows 0 after a step from 1.
- R5: A step taken while the count is 0 loads the period value held at that moment. A period write changes nothing until such a reload.
- R6: While en_i is low, the count and the prescale counter keep their values and no interrupt is raised.
- R7: A count write sets count_o on the next cycle, whether or not the timer is enabled. It takes priority over a step in the same cycle and never raises irq_o.
- R8: With a period of 0, a count at 0 stays at 0 on every step and no further interrupts occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer run enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 count, 1 period, 2 scale, 3 none |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Live count value |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Every result of this block is registered. A write, an enabled cycle or a prescaler expiry sampled at one rising edge therefore shows on count_o and irq_o from that edge until the next one. A count write is visible one cycle after its strobe, and the interrupt coincides with the first zero on count_o.

The bench predicts the count and interrupt for each rising edge from the inputs applied in that cycle. It queues that prediction and compares it against the outputs at the following falling edge, so every comparison lands exactly one register stage after its cause. The phases cover scale 0, 3 and 255, a disabled stretch, a period change in flight, count overrides, an unused address and a zero period.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_SCALE  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] period_o,
  output logic [PRE_W-1:0] scale_o,
  output logic             cnt_wr_o
);
  logic [CNT_W-1:0] period_q;
  logic [PRE_W-1:0] scale_q;

  assign cnt_wr_o = wr_en_i && (wr_sel_i == REG_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      scale_q  <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        REG_PERIOD: period_q <= wr_data_i;
        REG_SCALE:  scale_q  <= wr_data_i[PRE_W-1:0];
        default:    ;
      endcase
    end
  end

  assign period_o = period_q;
  assign scale_o  = scale_q;

  // unused select leaves storage alone
  assert_none_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == REG_NONE) |=> ($stable(period_q) && $stable(scale_q)));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] scale_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic             expire;

  assign expire = (pre_q == '0);
  assign tick_o = en_i && expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (en_i)   pre_q <= expire ? scale_i : pre_q - 1'b1;
  end

  assert_pre_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pre_q));
  assert_pre_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pre_q == $past(scale_i)));
  assert_pre_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> (pre_q == $past(pre_q) - 1'b1));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cnt_wr_i) begin
        cnt_q <= wr_data_i;
      end else if (tick_i) begin
        if (at_zero) begin
          cnt_q <= period_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          irq_q <= (cnt_q == ONE);
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  assert_irq_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_q == '0));
  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && at_zero) |=> (cnt_q == $past(period_i)));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr_i) |=> ($stable(cnt_q) && !irq_q));
  assert_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> ((cnt_q == $past(wr_data_i)) && !irq_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] period;
  logic [PRE_W-1:0] scale;
  logic             cnt_wr;
  logic             tick;

  timer_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (reg_sel_e'(wr_addr_i)),
    .wr_data_i (wr_data_i),
    .period_o  (period),
    .scale_o   (scale),
    .cnt_wr_o  (cnt_wr)
  );

  timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .scale_i (scale),
    .tick_o  (tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cnt_wr_i  (cnt_wr),
    .wr_data_i (wr_data_i),
    .period_i  (period),
    .count_o   (count_o),
    .irq_o     (irq_o)
  );

  assert_no_tick_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] count;
  logic        irq;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // expectation queues
  logic [15:0] q_cnt[$];
  logic        q_irq[$];
  string       q_tag[$];

  // requirement-level model state
  logic [15:0] m_cnt = '0, m_per = '0;
  logic [7:0]  m_scl = '0, m_pre = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(we),
    .wr_addr_i(addr), .wr_data_i(wdata), .count_o(count), .irq_o(irq)
  );

  // predictor: one expectation per rising edge out of reset
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_per = '0; m_scl = '0; m_pre = '0;
    end else begin
      logic tick, e_irq;
      tick  = en && (m_pre == 8'd0);
      e_irq = 1'b0;
      if (we && addr == 2'd0) m_cnt = wdata;
      else if (tick) begin
        if (m_cnt == 16'd0) m_cnt = m_per;
        else begin
          e_irq = (m_cnt == 16'd1);
          m_cnt = m_cnt - 16'd1;
        end
      end
      if (en) m_pre = (m_pre == 8'd0) ? m_scl : m_pre - 8'd1;
      if (we && addr == 2'd1) m_per = wdata;
      if (we && addr == 2'd2) m_scl = wdata[7:0];
      q_cnt.push_back(m_cnt);
      q_irq.push_back(e_irq);
      q_tag.push_back(cur_req);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (q_cnt.size() > 0) begin
      logic [15:0] ec;
      logic        ei;
      string       t;
      ec = q_cnt.pop_front();
      ei = q_irq.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (count !== ec || irq !== ei) begin
        errors++;
        $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b at %0t",
                 t, count, irq, ec, ei, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    run(3);
    // R1: reset state
    checks++;
    if (count !== 16'd0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: count=%0d irq=%0b expected count=0 irq=0", count, irq);
    end
    rst_n = 1'b1;
    run(2);
    cur_req = "R2";
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd0);
    cur_req = "R7";
    wr(2'd0, 16'd3);
    cur_req = "R4";
    en = 1'b1;
    run(20);
    cur_req = "R3";
    wr(2'd2, 16'h0003);
    run(45);
    cur_req = "R6";
    en = 1'b0;
    run(12);
    wr(2'd0, 16'd2);   // R7 while disabled
    run(5);
    en = 1'b1;
    cur_req = "R5";
    run(6);
    wr(2'd1, 16'd9);
    run(60);
    cur_req = "R7";
    wr(2'd0, 16'd1);
    run(10);
    cur_req = "R2";
    wr(2'd3, 16'h00ff);
    run(50);
    cur_req = "R3";
    wr(2'd2, 16'h00ff);
    wr(2'd1, 16'd2);
    wr(2'd0, 16'd2);
    run(1600);
    cur_req = "R8";
    wr(2'd2, 16'd0);
    run(300);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'd0);
    run(30);
    en = 1'b0;
    run(3);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run=unfinished expected=finished");
      summary();
      $finish;
    end
  end
endmodule